// File: doc/BRIEF.md
# CPU Architectural Register File with Pair Access

This block holds the programmer-visible state of a small 8-bit processor core: seven byte-wide general registers, a 16-bit stack pointer, a 16-bit program counter, the four condition flags (zero, subtract, half-carry, carry) and the interrupt master enable. The execute stage reads single registers by a 3-bit code and reads register pairs by a pair code. It writes results back through the same two kinds of port, and all reads are combinational from the current state.

Some address and stack arithmetic sits next to the storage. A pointer step port hands out the current HL value as a memory address and then moves HL up or down by one. A pair port packs the accumulator and the flags into one 16-bit stack word and unpacks them again. A 16-bit adjust unit performs the HL-plus-pair addition and the stack-pointer-plus-signed-byte addition, together with the flag rules for each. Every update takes effect at the next rising clock edge.

Top module: `cpu_regfile`

## Requirements
- R1: After reset the byte registers hold A=0x01, B=0x00, C=0x13, D=0x00, E=0xD8, H=0x01 and L=0x4D. SP holds 0xFFFE and PC holds 0x0100.
- R2: After reset the flags are Z=1, N=0, H=1 and C=1, and `ime` is 0. The flags appear on `flags` as {Z,N,H,C} in bits 3..0.
- R3: The byte register codes are B=0, C=1, D=2, E=3, H=4, L=5 and A=7. Code 6 always reads 0x00, and a write to code 6 changes no register.
- R4: The pair codes are BC=0, DE=1, HL=2, SP=3 and AF=4. For BC, DE and HL, the first-named register is the high byte on both read and write. Pair codes 5 to 7 read 0x0000, and a write to them changes nothing.
- R5: Pair AF reads as {A, Z, N, H, C, 4'b0000}. Writing pair AF loads A from bits 15..8 and loads Z, N, H and C from bits 7, 6, 5 and 4. Bits 3..0 of the written word are ignored.
- R6: `hl_addr` always shows the current HL. A step with direction 0 makes HL equal HL+1 at the next edge, and direction 1 makes it HL-1, wrapping modulo 2^16.
- R7: Adjust mode 0 adds the pair selected by `adj_src` (0 BC, 1 DE, 2 HL, 3 SP) to HL. H is set from the carry out of bit 11 and C from the carry out of bit 15. N is cleared and Z keeps its value.
- R8: Adjust modes 1 and 2 add the sign-extended `adj_off` to SP. Mode 1 writes the result to SP and mode 2 writes it to HL. H and C are the carries out of bits 3 and 7 of the unsigned sum of the low byte of SP and the raw offset byte. Z and N are cleared. Mode 3 does nothing.
- R9: When a pair write and a byte write hit the same register in one cycle, the pair write wins. The overall order, from highest to lowest, is pair write, adjust result, HL step, byte write. For the flags the order is pair write to AF, adjust flags, flag write port.
- R10: `ime_set` sets the interrupt enable and `ime_clr` clears it. When both are high in the same cycle, the enable is left cleared.
- R11: The flag write port updates only the flags whose bit in `flg_wr_mask` is 1, using the matching bit of `flg_wr_val` ({Z,N,H,C} in bits 3..0).
- R12: `pc_wr_en` loads `pc_wr_data` into PC at the next edge, and `pc` always shows the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| r8_rd_sel | input | 3 | Byte register read code |
| r8_rd_data | output | 8 | Byte register read data |
| r8_wr_en | input | 1 | Byte register write strobe |
| r8_wr_sel | input | 3 | Byte register write code |
| r8_wr_data | input | 8 | Byte register write data |
| pr_rd_sel | input | 3 | Pair read code |
| pr_rd_data | output | 16 | Pair read data |
| pr_wr_en | input | 1 | Pair write strobe |
| pr_wr_sel | input | 3 | Pair write code |
| pr_wr_data | input | 16 | Pair write data |
| hl_step_en | input | 1 | Step HL after use as an address |
| hl_step_dir | input | 1 | Step direction: 0 up, 1 down |
| hl_addr | output | 16 | Current HL as an address |
| adj_mode | input | 2 | Adjust operation: 0 HL add, 1 SP offset to SP, 2 SP offset to HL, 3 none |
| adj_src | input | 2 | Pair added to HL in mode 0 |
| adj_off | input | 8 | Signed offset for modes 1 and 2 |
| flg_wr_mask | input | 4 | Per-flag write mask {Z,N,H,C} |
| flg_wr_val | input | 4 | Flag write values {Z,N,H,C} |
| flags | output | 4 | Current flags {Z,N,H,C} |
| ime_set | input | 1 | Set the interrupt enable |
| ime_clr | input | 1 | Clear the interrupt enable |
| ime | output | 1 | Interrupt master enable |
| pc_wr_en | input | 1 | Program counter load strobe |
| pc_wr_data | input | 16 | Program counter load value |
| pc | output | 16 | Current program counter |

## Verification
The assertions on HL stepping and on the adjust flags only fire when no write of higher priority targets the same state in that cycle. They also assume the control inputs are never X. The directed stimulus drives every input to a known value on each falling edge. It returns all strobes to zero between operations, so each scenario either presents one operation alone or deliberately sets up the single pair-against-byte collision.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int NUM_R8  = 8;
    localparam int CODE_W  = $clog2(NUM_R8);
    localparam int FLAG_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [CODE_W-1:0] {
        R8_B    = 3'd0,
        R8_C    = 3'd1,
        R8_D    = 3'd2,
        R8_E    = 3'd3,
        R8_H    = 3'd4,
        R8_L    = 3'd5,
        R8_NONE = 3'd6,
        R8_A    = 3'd7
    } r8_code_e;

    typedef enum logic [2:0] {
        PR_BC = 3'd0,
        PR_DE = 3'd1,
        PR_HL = 3'd2,
        PR_SP = 3'd3,
        PR_AF = 3'd4
    } pair_code_e;

    typedef enum logic [1:0] {
        ADJ_HL_ADD   = 2'd0,
        ADJ_SP_TO_SP = 2'd1,
        ADJ_SP_TO_HL = 2'd2,
        ADJ_NONE     = 2'd3
    } adj_mode_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam word_t  SP_RESET    = 16'hFFFE;
    localparam word_t  PC_RESET    = 16'h0100;
    localparam flags_t FLAGS_RESET = '{z: 1'b1, n: 1'b0, h: 1'b1, c: 1'b1};

    function automatic byte_t r8_reset(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h13;
            2:       return 8'h00;
            3:       return 8'hD8;
            4:       return 8'h01;
            5:       return 8'h4D;
            7:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic word_t af_pack(input byte_t acc, input flags_t f);
        return {acc, f, 4'b0000};
    endfunction

    function automatic flags_t af_unpack_flags(input word_t w);
        return flags_t'(w[7:4]);
    endfunction

endpackage

// File: rtl/rf_pair_read.sv
module rf_pair_read
    import regfile_pkg::*;
(
    input  logic [NUM_R8-1:0][BYTE_W-1:0] gr,
    input  word_t                         sp,
    input  flags_t                        fl,
    input  logic [2:0]                    sel,
    output word_t                         data
);
    always_comb begin
        case (sel)
            PR_BC:   data = {gr[R8_B], gr[R8_C]};
            PR_DE:   data = {gr[R8_D], gr[R8_E]};
            PR_HL:   data = {gr[R8_H], gr[R8_L]};
            PR_SP:   data = sp;
            PR_AF:   data = af_pack(gr[R8_A], fl);
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/rf_adjust16.sv
module rf_adjust16
    import regfile_pkg::*;
(
    input  logic [1:0] mode,
    input  word_t      hl,
    input  word_t      sp,
    input  word_t      src,
    input  byte_t      off,
    input  flags_t     fl_in,
    output logic       valid,
    output logic       to_hl,
    output word_t      result,
    output flags_t     fl_out
);
    localparam int NIB_W = BYTE_W / 2;
    localparam int MID_W = 12;

    logic [WORD_W:0]   hl_sum;
    logic [MID_W:0]    hl_mid;
    logic [BYTE_W:0]   lo_sum;
    logic [NIB_W:0]    nib_sum;
    word_t             off_sx;

    always_comb begin
        hl_sum  = {1'b0, hl} + {1'b0, src};
        hl_mid  = {1'b0, hl[MID_W-1:0]} + {1'b0, src[MID_W-1:0]};
        off_sx  = {{(WORD_W-BYTE_W){off[BYTE_W-1]}}, off};
        lo_sum  = {1'b0, sp[BYTE_W-1:0]} + {1'b0, off};
        nib_sum = {1'b0, sp[NIB_W-1:0]} + {1'b0, off[NIB_W-1:0]};

        valid  = 1'b1;
        to_hl  = 1'b1;
        result = hl_sum[WORD_W-1:0];
        fl_out = fl_in;
        case (mode)
            ADJ_HL_ADD: begin
                fl_out.n = 1'b0;
                fl_out.h = hl_mid[MID_W];
                fl_out.c = hl_sum[WORD_W];
            end
            ADJ_SP_TO_SP, ADJ_SP_TO_HL: begin
                to_hl    = (mode == ADJ_SP_TO_HL);
                result   = sp + off_sx;
                fl_out.z = 1'b0;
                fl_out.n = 1'b0;
                fl_out.h = nib_sum[NIB_W];
                fl_out.c = lo_sum[BYTE_W];
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  r8_rd_sel,
    output logic [7:0]  r8_rd_data,
    input  logic        r8_wr_en,
    input  logic [2:0]  r8_wr_sel,
    input  logic [7:0]  r8_wr_data,
    input  logic [2:0]  pr_rd_sel,
    output logic [15:0] pr_rd_data,
    input  logic        pr_wr_en,
    input  logic [2:0]  pr_wr_sel,
    input  logic [15:0] pr_wr_data,
    input  logic        hl_step_en,
    input  logic        hl_step_dir,
    output logic [15:0] hl_addr,
    input  logic [1:0]  adj_mode,
    input  logic [1:0]  adj_src,
    input  logic [7:0]  adj_off,
    input  logic [3:0]  flg_wr_mask,
    input  logic [3:0]  flg_wr_val,
    output logic [3:0]  flags,
    input  logic        ime_set,
    input  logic        ime_clr,
    output logic        ime,
    input  logic        pc_wr_en,
    input  logic [15:0] pc_wr_data,
    output logic [15:0] pc
);
    logic [NUM_R8-1:0][BYTE_W-1:0] gr_q, gr_d;
    word_t  sp_q, sp_d, pc_q, pc_d;
    flags_t fl_q, fl_d;
    logic   ime_q, ime_d;

    word_t  hl_cur, adj_src_val, adj_res;
    logic   adj_valid, adj_to_hl;
    flags_t adj_fl;

    assign hl_cur = {gr_q[R8_H], gr_q[R8_L]};

    rf_pair_read u_rd_port (
        .gr(gr_q), .sp(sp_q), .fl(fl_q), .sel(pr_rd_sel), .data(pr_rd_data)
    );

    rf_pair_read u_rd_adj (
        .gr(gr_q), .sp(sp_q), .fl(fl_q), .sel({1'b0, adj_src}), .data(adj_src_val)
    );

    rf_adjust16 u_adj (
        .mode(adj_mode), .hl(hl_cur), .sp(sp_q), .src(adj_src_val), .off(adj_off),
        .fl_in(fl_q), .valid(adj_valid), .to_hl(adj_to_hl), .result(adj_res),
        .fl_out(adj_fl)
    );

    // Next state, lowest priority first so later assignments win.
    always_comb begin
        gr_d  = gr_q;
        sp_d  = sp_q;
        pc_d  = pc_q;
        fl_d  = flags_t'((fl_q & ~flg_wr_mask) | (flg_wr_val & flg_wr_mask));
        ime_d = ime_clr ? 1'b0 : (ime_set ? 1'b1 : ime_q);

        if (r8_wr_en && r8_wr_sel != R8_NONE)
            gr_d[r8_wr_sel] = r8_wr_data;

        if (hl_step_en)
            {gr_d[R8_H], gr_d[R8_L]} = hl_step_dir ? hl_cur - 16'd1 : hl_cur + 16'd1;

        if (adj_valid) begin
            fl_d = adj_fl;
            if (adj_to_hl) {gr_d[R8_H], gr_d[R8_L]} = adj_res;
            else           sp_d = adj_res;
        end

        if (pr_wr_en) begin
            case (pr_wr_sel)
                PR_BC: {gr_d[R8_B], gr_d[R8_C]} = pr_wr_data;
                PR_DE: {gr_d[R8_D], gr_d[R8_E]} = pr_wr_data;
                PR_HL: {gr_d[R8_H], gr_d[R8_L]} = pr_wr_data;
                PR_SP: sp_d = pr_wr_data;
                PR_AF: begin
                    gr_d[R8_A] = pr_wr_data[15:8];
                    fl_d       = af_unpack_flags(pr_wr_data);
                end
                default: ;
            endcase
        end

        if (pc_wr_en)
            pc_d = pc_wr_data;
    end

    generate
        for (genvar i = 0; i < NUM_R8; i++) begin : g_gr
            always_ff @(posedge clk) begin
                if (rst) gr_q[i] <= r8_reset(i);
                else     gr_q[i] <= gr_d[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= SP_RESET;
            pc_q  <= PC_RESET;
            fl_q  <= FLAGS_RESET;
            ime_q <= 1'b0;
        end else begin
            sp_q  <= sp_d;
            pc_q  <= pc_d;
            fl_q  <= fl_d;
            ime_q <= ime_d;
        end
    end

    assign r8_rd_data = (r8_rd_sel == R8_NONE) ? 8'h00 : gr_q[r8_rd_sel];
    assign hl_addr    = hl_cur;
    assign flags      = fl_q;
    assign ime        = ime_q;
    assign pc         = pc_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pc_q == PC_RESET && sp_q == SP_RESET && gr_q[R8_A] == 8'h01));

    // R6
    hl_step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (hl_step_en && !hl_step_dir && !pr_wr_en && adj_mode == ADJ_NONE)
        |=> (hl_addr == $past(hl_addr) + 16'd1));

    // R6
    hl_step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (hl_step_en && hl_step_dir && !pr_wr_en && adj_mode == ADJ_NONE)
        |=> (hl_addr == $past(hl_addr) - 16'd1));

    // R7
    hl_add_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_mode == ADJ_HL_ADD && !pr_wr_en)
        |=> (fl_q.z == $past(fl_q.z) && !fl_q.n));

    // R5
    af_unpack_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_wr_en && pr_wr_sel == PR_AF) |=> (flags == $past(pr_wr_data[7:4])));

    // R9
    pair_over_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_wr_en && pr_wr_sel == PR_BC && r8_wr_en && r8_wr_sel == R8_B)
        |=> (gr_q[R8_B] == $past(pr_wr_data[15:8])));

    // R10
    ime_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ime_set && ime_clr) |=> !ime);

endmodule

// File: tb/sim_cpu_regfile.sv
module sim_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  r8_rd_sel = '0;
    logic [7:0]  r8_rd_data;
    logic        r8_wr_en = 1'b0;
    logic [2:0]  r8_wr_sel = '0;
    logic [7:0]  r8_wr_data = '0;
    logic [2:0]  pr_rd_sel = '0;
    logic [15:0] pr_rd_data;
    logic        pr_wr_en = 1'b0;
    logic [2:0]  pr_wr_sel = '0;
    logic [15:0] pr_wr_data = '0;
    logic        hl_step_en = 1'b0;
    logic        hl_step_dir = 1'b0;
    logic [15:0] hl_addr;
    logic [1:0]  adj_mode = 2'd3;
    logic [1:0]  adj_src = '0;
    logic [7:0]  adj_off = '0;
    logic [3:0]  flg_wr_mask = '0;
    logic [3:0]  flg_wr_val = '0;
    logic [3:0]  flags;
    logic        ime_set = 1'b0;
    logic        ime_clr = 1'b0;
    logic        ime;
    logic        pc_wr_en = 1'b0;
    logic [15:0] pc_wr_data = '0;
    logic [15:0] pc;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cpu_regfile u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        r8_wr_en = 0; pr_wr_en = 0; hl_step_en = 0; adj_mode = 2'd3;
        flg_wr_mask = 0; ime_set = 0; ime_clr = 0; pc_wr_en = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd8(input logic [2:0] code, output logic [7:0] v);
        r8_rd_sel = code; #1; v = r8_rd_data;
    endtask

    task automatic rdp(input logic [2:0] code, output logic [15:0] v);
        pr_rd_sel = code; #1; pr_rd_data_hold = pr_rd_data; v = pr_rd_data_hold;
    endtask
    logic [15:0] pr_rd_data_hold;

    task automatic wrp(input logic [2:0] code, input logic [15:0] v);
        pr_wr_en = 1; pr_wr_sel = code; pr_wr_data = v; cyc();
    endtask

    task automatic wrflags(input logic [3:0] v);
        flg_wr_mask = 4'hF; flg_wr_val = v; cyc();
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [15:0] w;
        rd8(3'd7, b); chk("R1 A", {8'h0, b}, 16'h0001);
        rdp(3'd0, w); chk("R1 BC", w, 16'h0013);
        rdp(3'd1, w); chk("R1 DE", w, 16'h00D8);
        rdp(3'd2, w); chk("R1 HL", w, 16'h014D);
        rdp(3'd3, w); chk("R1 SP", w, 16'hFFFE);
        chk("R1 PC", pc, 16'h0100);
        chk("R2 flags", {12'h0, flags}, 16'h000B);
        chk("R2 ime", {15'h0, ime}, 16'h0000);
        rdp(3'd4, w); chk("R2 AF", w, 16'h01B0);
    endtask

    task automatic t_byte_rw();
        logic [7:0] b; logic [15:0] w;
        r8_wr_en = 1; r8_wr_sel = 3'd2; r8_wr_data = 8'h5A; cyc();
        rd8(3'd2, b); chk("R3 D write", {8'h0, b}, 16'h005A);
        rdp(3'd1, w); chk("R4 DE after D write", w, 16'h5AD8);
        r8_wr_en = 1; r8_wr_sel = 3'd6; r8_wr_data = 8'hFF; cyc();
        rd8(3'd6, b); chk("R3 code6 reads zero", {8'h0, b}, 16'h0000);
        rdp(3'd0, w); chk("R3 code6 BC intact", w, 16'h0013);
        rdp(3'd1, w); chk("R3 code6 DE intact", w, 16'h5AD8);
        rdp(3'd2, w); chk("R3 code6 HL intact", w, 16'h014D);
        rd8(3'd7, b); chk("R3 code6 A intact", {8'h0, b}, 16'h0001);
    endtask

    task automatic t_pairs();
        logic [7:0] b; logic [15:0] w;
        wrp(3'd0, 16'h1234);
        rd8(3'd0, b); chk("R4 B high", {8'h0, b}, 16'h0012);
        rd8(3'd1, b); chk("R4 C low", {8'h0, b}, 16'h0034);
        wrp(3'd3, 16'hC000);
        rdp(3'd3, w); chk("R4 SP write", w, 16'hC000);
        wrp(3'd6, 16'hBEEF);
        rdp(3'd6, w); chk("R4 code6 reads zero", w, 16'h0000);
        rdp(3'd0, w); chk("R4 code6 write ignored", w, 16'h1234);
    endtask

    task automatic t_af();
        logic [7:0] b; logic [15:0] w;
        wrp(3'd4, 16'h3C5F);
        rd8(3'd7, b); chk("R5 A unpack", {8'h0, b}, 16'h003C);
        chk("R5 flags unpack", {12'h0, flags}, 16'h0005);
        rdp(3'd4, w); chk("R5 AF low nibble zero", w, 16'h3C50);
    endtask

    task automatic t_hl_step();
        wrp(3'd2, 16'hFFFF);
        hl_step_en = 1; hl_step_dir = 0; #1;
        chk("R6 addr before inc", hl_addr, 16'hFFFF);
        cyc();
        chk("R6 inc wraps", hl_addr, 16'h0000);
        hl_step_en = 1; hl_step_dir = 1; #1;
        chk("R6 addr before dec", hl_addr, 16'h0000);
        cyc();
        chk("R6 dec wraps", hl_addr, 16'hFFFF);
    endtask

    task automatic t_hl_add();
        logic [15:0] w;
        wrp(3'd2, 16'h0FFF); wrp(3'd0, 16'h0001); wrflags(4'b1100);
        adj_mode = 2'd0; adj_src = 2'd0; cyc();
        rdp(3'd2, w); chk("R7 HL+BC result", w, 16'h1000);
        chk("R7 bit11 carry, Z kept", {12'h0, flags}, 16'h000A);
        wrp(3'd2, 16'h8000); wrp(3'd1, 16'h8000); wrflags(4'b0000);
        adj_mode = 2'd0; adj_src = 2'd1; cyc();
        rdp(3'd2, w); chk("R7 HL+DE wraps", w, 16'h0000);
        chk("R7 bit15 carry, zero result keeps Z", {12'h0, flags}, 16'h0001);
    endtask

    task automatic t_sp_off();
        logic [15:0] w;
        wrp(3'd3, 16'h00FF); wrflags(4'b1100);
        adj_mode = 2'd1; adj_off = 8'h01; cyc();
        rdp(3'd3, w); chk("R8 SP+1", w, 16'h0100);
        chk("R8 SP+1 flags", {12'h0, flags}, 16'h0003);
        wrp(3'd3, 16'h1000); wrflags(4'b1111);
        adj_mode = 2'd1; adj_off = 8'h80; cyc();
        rdp(3'd3, w); chk("R8 SP-128", w, 16'h0F80);
        chk("R8 SP-128 flags", {12'h0, flags}, 16'h0000);
        wrp(3'd3, 16'h0005); wrp(3'd2, 16'h1111);
        adj_mode = 2'd2; adj_off = 8'hFE; cyc();
        rdp(3'd2, w); chk("R8 HL=SP-2", w, 16'h0003);
        rdp(3'd3, w); chk("R8 SP kept in HL mode", w, 16'h0005);
        chk("R8 SP-2 flags", {12'h0, flags}, 16'h0003);
    endtask

    task automatic t_priority();
        logic [7:0] b;
        pr_wr_en = 1; pr_wr_sel = 3'd0; pr_wr_data = 16'hABCD;
        r8_wr_en = 1; r8_wr_sel = 3'd0; r8_wr_data = 8'h11; cyc();
        rd8(3'd0, b); chk("R9 pair beats byte on B", {8'h0, b}, 16'h00AB);
        rd8(3'd1, b); chk("R9 C from pair", {8'h0, b}, 16'h00CD);
    endtask

    task automatic t_ime();
        ime_set = 1; cyc(); chk("R10 set", {15'h0, ime}, 16'h0001);
        ime_set = 1; ime_clr = 1; cyc(); chk("R10 both clears", {15'h0, ime}, 16'h0000);
        ime_set = 1; cyc(); ime_clr = 1; cyc(); chk("R10 clear", {15'h0, ime}, 16'h0000);
    endtask

    task automatic t_flag_mask();
        wrflags(4'b1111);
        flg_wr_mask = 4'b1000; flg_wr_val = 4'b0000; cyc();
        chk("R11 mask Z only", {12'h0, flags}, 16'h0007);
        flg_wr_mask = 4'b0010; flg_wr_val = 4'b1101; cyc();
        chk("R11 mask H only", {12'h0, flags}, 16'h0005);
    endtask

    task automatic t_pc();
        pc_wr_en = 1; pc_wr_data = 16'h4321; cyc();
        chk("R12 pc load", pc, 16'h4321);
        cyc();
        chk("R12 pc holds", pc, 16'h4321);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_byte_rw();
        t_pairs();
        t_af();
        t_hl_step();
        t_hl_add();
        t_sp_off();
        t_priority();
        t_ime();
        t_flag_mask();
        t_pc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule